// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports one of three relations: greater, less or equal. It is built from identical 4-bit slices. Each slice compares its own bit pairs from the most significant pair downward. It also takes a three-wire relation code from the slice below it. That lower code decides the slice result only when every local bit pair matches. Otherwise the first unequal local pair, counted from the top bit, sets the result.

A parameterised chain joins the slices. Each slice's result feeds the next more-significant slice, and the top slice produces the final answer. The bottom slice is given the code for "equal". The top module holds two such chains. The first compares two free operands. The second compares one operand against a constant, 1578 by default, and also gives a greater-or-equal flag. The logic is purely combinational.

Top module: `mag_cmp_cascade`

## Requirements
- R1: For every input value, exactly one of `a_gt_o`, `a_lt_o`, `a_eq_o` is high, and exactly one of `x_gt_o`, `x_lt_o`, `x_eq_o` is high.
- R2: `a_gt_o` is high exactly when `a_i > b_i`, and `a_lt_o` is high exactly when `a_i < b_i`, both taken as unsigned numbers over the full width.
- R3: If the most significant slice's bits of `a_i` and `b_i` differ, that slice alone sets the result, whatever the lower slices hold.
- R4: If the upper slices are equal, the highest lower slice that holds unequal bits sets the result. It does so through the cascade code passed upward.
- R5: When `a_i == b_i` over the full width, `a_eq_o` is high. This follows from the bottom slice being fed the code greater=0, less=0, equal=1.
- R6: `x_gt_o`, `x_lt_o` and `x_eq_o` give the relation of `x_i` to the constant `KVAL`. With the defaults, 1577 gives less, 1578 gives equal and 1579 gives greater.
- R7: `x_ge_o` is high exactly when `x_i >= KVAL`.
- R8: Within one slice, the highest unequal bit pair decides the slice result. Lower bits of that slice are ignored. The exhaustive sweep of 8-bit operands covers this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | SLICE_W*SLICES (12) | First free operand |
| b_i | input | SLICE_W*SLICES (12) | Second free operand |
| x_i | input | SLICE_W*SLICES (12) | Operand compared against KVAL |
| a_gt_o | output | 1 | a_i greater than b_i |
| a_lt_o | output | 1 | a_i less than b_i |
| a_eq_o | output | 1 | a_i equal to b_i |
| x_gt_o | output | 1 | x_i greater than KVAL |
| x_lt_o | output | 1 | x_i less than KVAL |
| x_eq_o | output | 1 | x_i equal to KVAL |
| x_ge_o | output | 1 | x_i greater than or equal to KVAL |

## Verification
The block holds no stored state. A wrong internal value is a wrong cascade code between slices or a wrong priority within a slice. Either one shows at the relation outputs in the same evaluation that applies the operand. It can appear as two outputs high at once, or as a lower slice overriding a higher one. The bench therefore checks every output after each applied vector. It tags each mismatch with the precedence case that the vector exercises.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  localparam rel_t REL_EQUAL = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
endpackage

// File: rtl/cmp_bitpair.sv
module cmp_bitpair
  import magcmp_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output rel_t rel_o
);
  always_comb begin
    rel_o.gt = a_i & ~b_i;
    rel_o.lt = ~a_i & b_i;
    rel_o.eq = ~(a_i ^ b_i);
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import magcmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  rel_t               casc_i,
  output rel_t               rel_o
);
  rel_t bit_rel [SLICE_W];

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    cmp_bitpair u_bit (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .rel_o(bit_rel[i])
    );
  end

  // Walk upward from the lowest bit, so the highest unequal pair is the one that stays.
  // With every pair equal, the code from below passes through untouched.
  always_comb begin
    rel_o = casc_i;
    for (int i = 0; i < SLICE_W; i++) begin
      if (!bit_rel[i].eq) rel_o = bit_rel[i];
    end
  end
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import magcmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 3,
  localparam int OP_W   = SLICE_W * SLICES
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output rel_t            rel_o
);
  rel_t link [SLICES+1];

  assign link[0] = REL_EQUAL;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_i   (a_i[s*SLICE_W +: SLICE_W]),
      .b_i   (b_i[s*SLICE_W +: SLICE_W]),
      .casc_i(link[s]),
      .rel_o (link[s+1])
    );
  end

  assign rel_o = link[SLICES];
endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import magcmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 3,
  parameter int KVAL    = 1578,
  localparam int OP_W   = SLICE_W * SLICES
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic [OP_W-1:0] x_i,
  output logic            a_gt_o,
  output logic            a_lt_o,
  output logic            a_eq_o,
  output logic            x_gt_o,
  output logic            x_lt_o,
  output logic            x_eq_o,
  output logic            x_ge_o
);
  localparam logic [OP_W-1:0] KVEC = OP_W'(KVAL);

  rel_t ab_rel;
  rel_t xk_rel;

  cmp_chain #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_ab (
    .a_i  (a_i),
    .b_i  (b_i),
    .rel_o(ab_rel)
  );

  cmp_chain #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_xk (
    .a_i  (x_i),
    .b_i  (KVEC),
    .rel_o(xk_rel)
  );

  assign a_gt_o = ab_rel.gt;
  assign a_lt_o = ab_rel.lt;
  assign a_eq_o = ab_rel.eq;
  assign x_gt_o = xk_rel.gt;
  assign x_lt_o = xk_rel.lt;
  assign x_eq_o = xk_rel.eq;
  assign x_ge_o = xk_rel.gt | xk_rel.eq;
endmodule

// File: rtl/mag_cmp_cascade_chk.sv
module mag_cmp_cascade_chk #(
  parameter int OP_W = 12,
  parameter int KVAL = 1578
) (
  input logic [OP_W-1:0] a_i,
  input logic [OP_W-1:0] b_i,
  input logic [OP_W-1:0] x_i,
  input logic            a_gt_o,
  input logic            a_lt_o,
  input logic            a_eq_o,
  input logic            x_gt_o,
  input logic            x_lt_o,
  input logic            x_eq_o,
  input logic            x_ge_o
);
  localparam logic [OP_W-1:0] KVEC = OP_W'(KVAL);

  always_comb begin
    a_r1_ab_onehot: assert ($countones({a_gt_o, a_lt_o, a_eq_o}) == 1)
      else $error("ab relation not one-hot");
    a_r1_xk_onehot: assert ($countones({x_gt_o, x_lt_o, x_eq_o}) == 1)
      else $error("constant relation not one-hot");
    a_r2_gt_order: assert (a_gt_o == (a_i > b_i))
      else $error("greater flag disagrees with operands");
    a_r2_lt_order: assert (a_lt_o == (a_i < b_i))
      else $error("less flag disagrees with operands");
    a_r5_equal: assert (!(a_i == b_i) || a_eq_o)
      else $error("equal operands not reported equal");
    a_r6_const_eq: assert (x_eq_o == (x_i == KVEC))
      else $error("constant equality wrong");
    a_r7_const_ge: assert (x_ge_o == (x_i >= KVEC))
      else $error("greater-or-equal flag wrong");
  end
endmodule

bind mag_cmp_cascade mag_cmp_cascade_chk #(.OP_W(OP_W), .KVAL(KVAL)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .x_i   (x_i),
  .a_gt_o(a_gt_o),
  .a_lt_o(a_lt_o),
  .a_eq_o(a_eq_o),
  .x_gt_o(x_gt_o),
  .x_lt_o(x_lt_o),
  .x_eq_o(x_eq_o),
  .x_ge_o(x_ge_o)
);

// File: tb/mag_cmp_cascade_test.sv
module mag_cmp_cascade_test;
  localparam int SW   = 4;
  localparam int NS   = 3;
  localparam int W    = SW * NS;
  localparam int KV   = 1578;

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b, x;
  logic a_gt, a_lt, a_eq, x_gt, x_lt, x_eq, x_ge;
  int n_vec;
  int n_bad;
  bit done;

  mag_cmp_cascade #(.SLICE_W(SW), .SLICES(NS), .KVAL(KV)) uut (
    .a_i(a), .b_i(b), .x_i(x),
    .a_gt_o(a_gt), .a_lt_o(a_lt), .a_eq_o(a_eq),
    .x_gt_o(x_gt), .x_lt_o(x_lt), .x_eq_o(x_eq), .x_ge_o(x_ge)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d x=%0d got=%b exp=%b", req, a, b, x, got, exp);
    end
  endtask

  function automatic string ab_tag(input logic [W-1:0] va, input logic [W-1:0] vb);
    if (va == vb) return "R5";
    if (va[W-1 -: SW] != vb[W-1 -: SW]) return "R3";
    return "R4";
  endfunction

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic [W-1:0] vx, input string base);
    @(negedge clk);
    a = va; b = vb; x = vx;
    #1;
    check("R1", 3'(($countones({a_gt, a_lt, a_eq}) == 1) && ($countones({x_gt, x_lt, x_eq}) == 1)), 3'd1);
    check({base, " ", ab_tag(va, vb)}, {a_gt, a_lt, a_eq}, {va > vb, va < vb, va == vb});
    check("R6", {x_gt, x_lt, x_eq}, {vx > W'(KV), vx < W'(KV), vx == W'(KV)});
    check("R7", {2'b00, x_ge}, {2'b00, vx >= W'(KV)});
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    a = '0; b = '0; x = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R5 with all-zero and all-one operands
    apply('0, '0, '0, "R5");
    apply('1, '1, '1, "R5");
    // R6 boundary values around the constant
    apply(W'(1577), W'(1578), W'(1577), "R6");
    apply(W'(1578), W'(1578), W'(1578), "R6");
    apply(W'(1579), W'(1578), W'(1579), "R6");
    // R8 / R2: exhaustive sweep of 8-bit operands covers every bit priority in two slices
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(W'(i), W'(j), W'(i * 16 + j), "R2 R8");
      end
    end
    // R3 / R4: random 12-bit operands, with shared upper slices half the time
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (k[0]) rb[W-1 -: SW] = ra[W-1 -: SW];
      if (k[1]) rb[W-SW-1 -: SW] = ra[W-SW-1 -: SW];
      apply(ra, rb, W'($urandom), "R2");
    end
    // R6 / R7: full sweep of the constant comparison
    for (int v = 0; v < (1 << W); v++) begin
      apply(W'(v), W'(v ^ 1), W'(v), "R2");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule